// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind an HDLC deframer and decides, early in each received frame, whether the frame is addressed to this station. The deframer hands it a start-of-frame strobe once the opening flag has been stripped, then the frame's bytes one at a time with a byte-valid strobe, and finally an end-of-frame strobe. The filter gathers the leading address bytes into a comparison word and masks that word with one shared programmable mask. It then compares the result against a small bank of programmable station addresses, each masked the same way.

The first address byte lands in the low byte of the comparison word and the second in the next byte up. Single-byte addressing needs no mode switch: software clears the upper half of the mask, and the filter then decides after only one byte. One cycle after the deciding byte arrives, the block pulses a decision strobe with an accept flag and the index of the lowest-numbered matching address register. Downstream logic can therefore keep or drop the rest of the frame. A bypass input turns filtering off and accepts everything. Mask and address registers are written through a plain write port into a pending copy, which is moved into the working copy only at the start of the next frame.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset dec_valid, dec_accept and dec_hit_idx are low, the working mask is all ones and every working address register is zero, so a first frame with address bytes 0x00, 0x00 is accepted with index 0.
- R2: The first address byte forms bits 7:0 of the comparison word and the second byte forms bits 15:8; with mask 0xFFFF, a frame whose address bytes are 0x68 then 0xAA matches a register holding 0xAA68.
- R3: A register matches when (comparison word AND mask) equals (register AND mask); when several match, dec_hit_idx gives the lowest register number; when none match, dec_accept is 0 and dec_hit_idx is 0.
- R4: When mask bits 15:8 are all zero, only the first address byte is used, register bits 15:8 have no effect on the result, and the decision pulse comes in the cycle after the first byte.
- R5: When any of mask bits 15:8 is set, no decision is issued after the first byte, and the decision pulse comes in the cycle after the second byte.
- R6: Each frame yields exactly one single-cycle dec_valid pulse; bytes after the deciding byte, bytes outside a frame (before any rx_sof or after rx_eof) and the rx_sof cycle itself never produce a decision.
- R7: A frame whose rx_eof arrives before the needed address bytes are complete (an end strobe together with the last byte counts that byte first) yields a decision in the cycle after rx_eof with dec_accept 0 and dec_hit_idx 0.
- R8: When filt_en is low in the cycle of the deciding byte or end strobe, the decision has dec_accept 1 and dec_hit_idx 0, including for short frames.
- R9: cfg_sel values 0 to 3 write address registers 0 to 3 and value 4 writes the mask; a write reaches the comparison only at the next rx_sof, so a frame already under way keeps its mask, its address values and its byte count.
- R10: A broadcast value in one register and a station address in another are recognised together, and the same value may be loaded into every register, in which case a match reports index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_en | input | 1 | 1 = filter by address, 0 = accept every frame |
| cfg_we | input | 1 | Write strobe for the pending register copy |
| cfg_sel | input | 3 | Register select: 0..3 address registers, 4 mask, other values write nothing |
| cfg_wdata | input | 16 | Write data |
| rx_sof | input | 1 | Start of frame, a cycle of its own after the opening flag; byte and end strobes in this cycle are not used |
| rx_valid | input | 1 | rx_data carries a frame byte |
| rx_data | input | 8 | Received frame byte |
| rx_eof | input | 1 | End of frame; a byte presented in the same cycle is taken first |
| dec_valid | output | 1 | One-cycle pulse carrying the frame decision |
| dec_accept | output | 1 | 1 = keep the frame, valid with dec_valid |
| dec_hit_idx | output | 2 | Lowest matching register number, 0 on discard or bypass |

## Verification
The bench sweeps grids of first and second address bytes against several masks, covering full 16-bit, 8-bit, mixed-nibble, all-zero and upper-only masks, and works out each expected decision arithmetically. A design that swapped the byte order would fail the 0x68/0xAA case. A design that let register bits 15:8 count under an 8-bit mask would reject 0x55 against 0x1155. One that kept a fixed two-byte wait would miss the decision cycle after the first byte. Duplicate and broadcast entries catch a priority encoder that picks the highest index. Short frames with zero or one byte, trailing payload bytes and bytes sent with no frame open catch a missing, late or repeated decision pulse. Writes to the address and mask registers in the middle of a frame catch a design that applies them at once instead of at the next start of frame.

// File: rtl/haf_pkg.sv
package haf_pkg;

   // Address collection progress within one frame
   typedef enum logic [1:0] {
      CAP_IDLE    = 2'd0,
      CAP_COLLECT = 2'd1,
      CAP_DONE    = 2'd2
   } cap_state_e;

   // Decision payload registered at the block edge
   typedef struct packed {
      logic valid;
      logic accept;
   } dec_flags_t;

endpackage

// File: rtl/haf_cfg_bank.sv
module haf_cfg_bank #(
   parameter int NUM_ADDR = 4,
   parameter int ADDR_W   = 16,
   parameter int SEL_W    = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [SEL_W-1:0]                  cfg_sel,
   input  logic [ADDR_W-1:0]                 cfg_wdata,
   input  logic                              load,
   output logic [NUM_ADDR-1:0][ADDR_W-1:0]   act_addr,
   output logic [ADDR_W-1:0]                 act_mask
);

   logic [NUM_ADDR-1:0][ADDR_W-1:0] pend_addr;
   logic [ADDR_W-1:0]               pend_mask;

   // Pending copy: written by software at any time
   for (genvar i = 0; i < NUM_ADDR; i++) begin : g_pend
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_addr[i] <= '0;
         end else if (cfg_we && (cfg_sel == SEL_W'(i))) begin
            pend_addr[i] <= cfg_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_mask <= '1;
      end else if (cfg_we && (cfg_sel == SEL_W'(NUM_ADDR))) begin
         pend_mask <= cfg_wdata;
      end
   end

   // Working copy: refreshed only at a frame boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_addr <= '0;
         act_mask <= '1;
      end else if (load) begin
         act_addr <= pend_addr;
         act_mask <= pend_mask;
      end
   end

endmodule

// File: rtl/haf_byte_capture.sv
module haf_byte_capture
   import haf_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int ADDR_BYTES = 2,
   localparam int ADDR_W    = BYTE_W * ADDR_BYTES,
   localparam int CNT_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_sof,
   input  logic               rx_valid,
   input  logic [BYTE_W-1:0]  rx_data,
   input  logic               rx_eof,
   input  logic [CNT_W-1:0]   need_m1,
   output logic               issue,
   output logic               complete,
   output logic [ADDR_W-1:0]  cand
);

   cap_state_e         state;
   logic [CNT_W-1:0]   cnt;
   logic [ADDR_W-1:0]  cap;
   logic               collecting;
   logic               take;

   assign collecting = (state == CAP_COLLECT) && !rx_sof;
   assign take       = collecting && rx_valid;
   assign complete   = take && (cnt == need_m1);
   assign issue      = collecting && (complete || rx_eof);

   // Comparison word: stored bytes with the current byte merged at its slot
   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_slot
      assign cand[k*BYTE_W +: BYTE_W] =
         (take && (cnt == CNT_W'(k))) ? rx_data : cap[k*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CAP_IDLE;
         cnt   <= '0;
         cap   <= '0;
      end else if (rx_sof) begin
         state <= CAP_COLLECT;
         cnt   <= '0;
         cap   <= '0;
      end else begin
         unique case (state)
            CAP_COLLECT: begin
               if (issue) begin
                  state <= rx_eof ? CAP_IDLE : CAP_DONE;
               end else if (take) begin
                  cap <= cand;
                  cnt <= cnt + CNT_W'(1);
               end
            end
            CAP_DONE: begin
               if (rx_eof) state <= CAP_IDLE;
            end
            default: state <= CAP_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/haf_match.sv
module haf_match #(
   parameter int NUM_ADDR = 4,
   parameter int ADDR_W   = 16,
   parameter int IDX_W    = 2
) (
   input  logic [ADDR_W-1:0]                cand,
   input  logic [NUM_ADDR-1:0][ADDR_W-1:0]  act_addr,
   input  logic [ADDR_W-1:0]                act_mask,
   output logic                             hit,
   output logic [IDX_W-1:0]                 hit_idx
);

   logic [NUM_ADDR-1:0] eq;

   for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
      assign eq[i] = ((cand ^ act_addr[i]) & act_mask) == '0;
   end

   // Lowest index wins: scan downward so the last assignment is the smallest
   always_comb begin
      hit     = |eq;
      hit_idx = '0;
      for (int i = NUM_ADDR - 1; i >= 0; i--) begin
         if (eq[i]) hit_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
   import haf_pkg::*;
#(
   parameter int  NUM_ADDR   = 4,
   parameter int  BYTE_W     = 8,
   parameter int  ADDR_BYTES = 2,
   localparam int ADDR_W     = BYTE_W * ADDR_BYTES,
   localparam int IDX_W      = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1,
   localparam int SEL_W      = $clog2(NUM_ADDR + 1),
   localparam int CNT_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               filt_en,
   input  logic               cfg_we,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [ADDR_W-1:0]  cfg_wdata,
   input  logic               rx_sof,
   input  logic               rx_valid,
   input  logic [BYTE_W-1:0]  rx_data,
   input  logic               rx_eof,
   output logic               dec_valid,
   output logic               dec_accept,
   output logic [IDX_W-1:0]   dec_hit_idx
);

   // Elaboration-time parameter checks
   if (NUM_ADDR < 2) begin : g_chk_num
      $error("hdlc_addr_filter: NUM_ADDR must be at least 2");
   end
   if (BYTE_W < 1) begin : g_chk_byte
      $error("hdlc_addr_filter: BYTE_W must be positive");
   end
   if (ADDR_BYTES < 1) begin : g_chk_bytes
      $error("hdlc_addr_filter: ADDR_BYTES must be positive");
   end

   logic [NUM_ADDR-1:0][ADDR_W-1:0] act_addr;
   logic [ADDR_W-1:0]               act_mask;
   logic [CNT_W-1:0]                need_m1;
   logic                            issue;
   logic                            complete;
   logic [ADDR_W-1:0]               cand;
   logic                            hit;
   logic [IDX_W-1:0]                hit_idx;
   dec_flags_t                      dec_q;
   logic [IDX_W-1:0]                idx_q;

   haf_cfg_bank #(
      .NUM_ADDR (NUM_ADDR),
      .ADDR_W   (ADDR_W),
      .SEL_W    (SEL_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .load      (rx_sof),
      .act_addr  (act_addr),
      .act_mask  (act_mask)
   );

   // Number of address bytes needed: one past the highest masked-in byte
   if (ADDR_BYTES == 1) begin : g_need_one
      assign need_m1 = '0;
   end else begin : g_need_multi
      always_comb begin
         need_m1 = '0;
         for (int k = 1; k < ADDR_BYTES; k++) begin
            if (|act_mask[k*BYTE_W +: BYTE_W]) need_m1 = CNT_W'(k);
         end
      end
   end

   haf_byte_capture #(
      .BYTE_W     (BYTE_W),
      .ADDR_BYTES (ADDR_BYTES)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_sof   (rx_sof),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .rx_eof   (rx_eof),
      .need_m1  (need_m1),
      .issue    (issue),
      .complete (complete),
      .cand     (cand)
   );

   haf_match #(
      .NUM_ADDR (NUM_ADDR),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W)
   ) u_match (
      .cand     (cand),
      .act_addr (act_addr),
      .act_mask (act_mask),
      .hit      (hit),
      .hit_idx  (hit_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_q <= '0;
         idx_q <= '0;
      end else begin
         dec_q.valid <= issue;
         if (issue && !filt_en) begin
            dec_q.accept <= 1'b1;
            idx_q        <= '0;
         end else if (issue && complete && hit) begin
            dec_q.accept <= 1'b1;
            idx_q        <= hit_idx;
         end else begin
            dec_q.accept <= 1'b0;
            idx_q        <= '0;
         end
      end
   end

   assign dec_valid   = dec_q.valid;
   assign dec_accept  = dec_q.accept;
   assign dec_hit_idx = idx_q;

endmodule

// File: rtl/haf_checker.sv
module haf_checker #(
   parameter int NUM_ADDR = 4,
   parameter int ADDR_W   = 16,
   parameter int IDX_W    = 2
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             filt_en,
   input logic                             rx_sof,
   input logic                             dec_valid,
   input logic                             dec_accept,
   input logic [IDX_W-1:0]                 dec_hit_idx,
   input logic [NUM_ADDR-1:0][ADDR_W-1:0]  act_addr,
   input logic [ADDR_W-1:0]                act_mask
);

   // R6
   dec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   // R6
   sof_no_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_sof |=> !dec_valid);

   // R3
   discard_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_accept) |-> (dec_hit_idx == '0));

   // R8
   bypass_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_en |=> (!dec_valid || (dec_accept && dec_hit_idx == '0)));

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_sof |=> ($stable(act_mask) && $stable(act_addr)));

endmodule

bind hdlc_addr_filter haf_checker #(
   .NUM_ADDR (NUM_ADDR),
   .ADDR_W   (ADDR_W),
   .IDX_W    (IDX_W)
) u_haf_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .filt_en     (filt_en),
   .rx_sof      (rx_sof),
   .dec_valid   (dec_valid),
   .dec_accept  (dec_accept),
   .dec_hit_idx (dec_hit_idx),
   .act_addr    (act_addr),
   .act_mask    (act_mask)
);

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        filt_en = 1'b1;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic        rx_sof = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_eof = 1'b0;
   logic        dec_valid;
   logic        dec_accept;
   logic [1:0]  dec_hit_idx;

   int checks = 0;
   int failures = 0;

   // Bench model of the pending and working register copies
   logic [15:0] p_addr [4];
   logic [15:0] p_mask;
   logic [15:0] a_addr [4];
   logic [15:0] a_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_addr_filter dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .filt_en     (filt_en),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_wdata   (cfg_wdata),
      .rx_sof      (rx_sof),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .rx_eof      (rx_eof),
      .dec_valid   (dec_valid),
      .dec_accept  (dec_accept),
      .dec_hit_idx (dec_hit_idx)
   );

   task automatic check_dec(input string req, input bit exp_v, input bit exp_a, input int exp_i);
      checks++;
      if (dec_valid !== exp_v) begin
         failures++;
         $display("FAIL %s dec_valid actual=%b expected=%b", req, dec_valid, exp_v);
      end else if (exp_v && (dec_accept !== exp_a || dec_hit_idx !== 2'(exp_i))) begin
         failures++;
         $display("FAIL %s accept/idx actual=%b/%0d expected=%b/%0d",
                  req, dec_accept, dec_hit_idx, exp_a, exp_i);
      end
   endtask

   task automatic model(input int nb, input logic [7:0] b0, input logic [7:0] b1,
                        output bit acc, output int idx);
      int need;
      logic [15:0] w;
      need = (a_mask[15:8] != 8'h00) ? 2 : 1;
      w = {b1, b0};
      acc = 1'b0;
      idx = 0;
      if (!filt_en) begin
         acc = 1'b1;
      end else if (nb >= need) begin
         for (int i = 3; i >= 0; i--) begin
            if (((w ^ a_addr[i]) & a_mask) == 16'h0000) begin
               acc = 1'b1;
               idx = i;
            end
         end
      end
   endtask

   task automatic wr_cfg(input logic [2:0] sel, input logic [15:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel < 3'd4) p_addr[sel] = data;
      else if (sel == 3'd4) p_mask = data;
   endtask

   // One frame: sof cycle, nb bytes (end strobe with the last byte), optional
   // register write alongside the first byte
   task automatic send_frame(input int nb, input logic [7:0] b0, input logic [7:0] b1,
                             input bit wr, input logic [2:0] wsel, input logic [15:0] wdat,
                             input string req);
      bit acc;
      int idx;
      int need;
      int dec_at;
      logic [7:0] bytes [3];
      bytes[0] = b0; bytes[1] = b1; bytes[2] = 8'h44;
      @(negedge clk);
      rx_sof = 1'b1;
      @(negedge clk);
      rx_sof = 1'b0;
      a_addr = p_addr;
      a_mask = p_mask;
      need = (a_mask[15:8] != 8'h00) ? 2 : 1;
      model(nb, b0, b1, acc, idx);
      dec_at = (nb < need) ? nb - 1 : need - 1;
      if (nb == 0) begin
         rx_eof = 1'b1;
         @(negedge clk);
         rx_eof = 1'b0;
         check_dec(req, 1'b1, acc, idx);
      end
      for (int k = 0; k < nb; k++) begin
         rx_valid = 1'b1;
         rx_data  = bytes[k];
         rx_eof   = (k == nb - 1);
         if (wr && k == 0) begin
            cfg_we = 1'b1; cfg_sel = wsel; cfg_wdata = wdat;
         end
         @(negedge clk);
         cfg_we = 1'b0;
         if (wr && k == 0) begin
            if (wsel < 3'd4) p_addr[wsel] = wdat;
            else if (wsel == 3'd4) p_mask = wdat;
         end
         check_dec(req, (k == dec_at), acc, idx);
      end
      rx_valid = 1'b0;
      rx_eof   = 1'b0;
      @(negedge clk);
      check_dec({req, " R6 trailing"}, 1'b0, 1'b0, 0);
   endtask

   task automatic run_all();
      // Reset
      for (int i = 0; i < 4; i++) p_addr[i] = 16'h0000;
      p_mask = 16'hFFFF;
      a_addr = p_addr;
      a_mask = p_mask;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_dec("R1 reset", 1'b0, 1'b0, 0);
      if (dec_accept !== 1'b0 || dec_hit_idx !== 2'd0) begin
         failures++;
         $display("FAIL R1 reset outputs actual=%b/%0d expected=0/0", dec_accept, dec_hit_idx);
      end
      checks++;

      // R6: bytes with no frame open
      for (int k = 0; k < 3; k++) begin
         rx_valid = 1'b1; rx_data = 8'(k); rx_eof = (k == 2);
         @(negedge clk);
         check_dec("R6 no frame", 1'b0, 1'b0, 0);
      end
      rx_valid = 1'b0; rx_eof = 1'b0;

      send_frame(2, 8'h00, 8'h00, 1'b0, 3'd0, 16'h0, "R1 default regs");

      // R2/R10: 16-bit mask, unicast plus broadcast plus duplicate
      wr_cfg(3'd0, 16'hAA68);
      wr_cfg(3'd1, 16'hFFFF);
      wr_cfg(3'd2, 16'h1234);
      wr_cfg(3'd3, 16'hAA68);
      send_frame(3, 8'h68, 8'hAA, 1'b0, 3'd0, 16'h0, "R2 byte order");
      send_frame(2, 8'hAA, 8'h68, 1'b0, 3'd0, 16'h0, "R2 swapped miss");
      send_frame(2, 8'hFF, 8'hFF, 1'b0, 3'd0, 16'h0, "R10 broadcast");
      send_frame(2, 8'h34, 8'h12, 1'b0, 3'd0, 16'h0, "R3 idx2");
      send_frame(3, 8'h68, 8'hAB, 1'b0, 3'd0, 16'h0, "R5 miss");
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++)
            send_frame(2, 8'(i*17), 8'(j*17), 1'b0, 3'd0, 16'h0, "R3 grid16");

      // R7: short frames under a 16-bit mask
      send_frame(0, 8'h00, 8'h00, 1'b0, 3'd0, 16'h0, "R7 empty");
      send_frame(1, 8'h68, 8'h00, 1'b0, 3'd0, 16'h0, "R7 one byte");

      // R4: 8-bit mask, upper register bits differ
      wr_cfg(3'd0, 16'h1155);
      wr_cfg(3'd1, 16'h2255);
      wr_cfg(3'd2, 16'h33AA);
      wr_cfg(3'd3, 16'h4400);
      wr_cfg(3'd4, 16'h00FF);
      for (int b = 0; b < 256; b++)
         send_frame(2, 8'(b), 8'h44, 1'b0, 3'd0, 16'h0, "R4 sweep8");
      send_frame(0, 8'h00, 8'h00, 1'b0, 3'd0, 16'h0, "R7 empty 8-bit");

      // R3: mixed-nibble mask
      wr_cfg(3'd0, 16'h0A05);
      wr_cfg(3'd1, 16'h0B06);
      wr_cfg(3'd2, 16'h1111);
      wr_cfg(3'd3, 16'hFFFF);
      wr_cfg(3'd4, 16'h0F0F);
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++)
            send_frame(2, 8'(i*17), 8'(j*17), 1'b0, 3'd0, 16'h0, "R3 nibble grid");

      // R4: all-zero mask decides after one byte, index 0
      wr_cfg(3'd4, 16'h0000);
      send_frame(1, 8'h9C, 8'h00, 1'b0, 3'd0, 16'h0, "R4 zero mask");
      // R5: upper-only mask still waits for the second byte
      wr_cfg(3'd4, 16'hF000);
      send_frame(2, 8'h00, 8'hF7, 1'b0, 3'd0, 16'h0, "R5 upper mask");
      send_frame(1, 8'h00, 8'h00, 1'b0, 3'd0, 16'h0, "R7 upper mask short");

      // R10: same value everywhere
      for (int i = 0; i < 4; i++) wr_cfg(3'(i), 16'h7777);
      wr_cfg(3'd4, 16'hFFFF);
      send_frame(2, 8'h77, 8'h77, 1'b0, 3'd0, 16'h0, "R10 duplicates");

      // R8: bypass
      filt_en = 1'b0;
      send_frame(2, 8'h01, 8'h02, 1'b0, 3'd0, 16'h0, "R8 bypass miss");
      send_frame(1, 8'h01, 8'h00, 1'b0, 3'd0, 16'h0, "R8 bypass short");
      send_frame(0, 8'h00, 8'h00, 1'b0, 3'd0, 16'h0, "R8 bypass empty");
      filt_en = 1'b1;

      // R9: writes during a frame wait for the next start
      wr_cfg(3'd0, 16'hAA68);
      wr_cfg(3'd1, 16'h0001);
      wr_cfg(3'd2, 16'h0002);
      wr_cfg(3'd3, 16'h0003);
      send_frame(2, 8'h68, 8'hAA, 1'b1, 3'd0, 16'h1111, "R9 addr held");
      send_frame(2, 8'h68, 8'hAA, 1'b0, 3'd0, 16'h0, "R9 addr applied");
      send_frame(2, 8'h11, 8'h11, 1'b1, 3'd4, 16'h00FF, "R9 mask held");
      send_frame(2, 8'h11, 8'h99, 1'b0, 3'd0, 16'h0, "R9 mask applied");
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (WATCHDOG) @(posedge clk);
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule